// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block keeps the bookkeeping for a ring of `NWIN` register windows. Four counters describe the ring: windows free to be claimed by a call (`can_save`), windows holding live frames that a return can reopen (`can_restore`), windows that belong to another context (`other_win`), and windows already scrubbed for reuse (`clean_win`). A pointer, `cwp`, names the active window. One request is presented per cycle on `req_valid`/`req_op`. A request either moves the counters and the pointer, or it raises a trap. The trap carries a 9-bit type so that an outside handler can spill frames to memory, fill them back, or clean a window.

The trap type combines a base code with three bits taken from a 6-bit window-state input `wstate`. The upper half of `wstate` is used when other-context windows are present. The lower half is used otherwise. The handler reports completed spills and fills with the `saved` and `restored` requests. A load request presets all four counters from `load_val` for context switches.

The control is a two-state machine. `ST_READY` is the normal state. `ST_TRAP` is entered for exactly one cycle after any request that traps, and `trap_valid` is high while the machine is in `ST_TRAP`. The transition `READY->TRAP` or `TRAP->TRAP` is taken on a trapping request. The transition `TRAP->READY` or `READY->READY` is taken otherwise.

Top module: `wsc_unit`

## Requirements
- R1: After reset, `can_save` = NWIN-2, `clean_win` = NWIN-1, `can_restore` = `other_win` = `cwp` = 0, `trap_valid` = 0 and `trap_type` = 0.
- R2: A save request (`req_op` = 0) with `can_save` nonzero and `clean_win` different from `can_restore` decrements `can_save`, increments `can_restore` and steps `cwp` down by one.
- R3: A save request with `can_save` = 0 raises a spill trap and leaves every counter and `cwp` unchanged.
- R4: A save request with `can_save` nonzero and `clean_win` equal to `can_restore` raises trap type 0x024 and changes no counter and not `cwp`.
- R5: A restore request (`req_op` = 1) with `can_restore` = 0 raises a fill trap and changes nothing else. Otherwise it increments `can_save`, decrements `can_restore` and steps `cwp` up by one.
- R6: A spill trap type is 0x080 and a fill trap type is 0x0C0, each ORed with a selector term. When `other_win` is nonzero, the selector term is 0x020 plus `wstate[5:3]` placed in type bits [4:2]. When `other_win` is zero, the selector term is `wstate[2:0]` placed in bits [4:2].
- R7: A flush request (`req_op` = 4) raises a spill trap unless `can_save` equals NWIN-2. The flush never alters the counters or `cwp`.
- R8: A saved request (`req_op` = 2) increments `can_save`. It then decrements `other_win` if that is nonzero, and decrements `can_restore` otherwise.
- R9: A restored request (`req_op` = 3) increments `can_restore`. It increments `clean_win` only while `clean_win` is below NWIN-1. It then decrements `other_win` if that is nonzero, and decrements `can_save` otherwise.
- R10: Counter, pointer and trap outputs take their new values at the clock edge that samples the request. `trap_valid` is high for exactly that one following cycle, and `trap_type` is 0 whenever `trap_valid` is low. Request codes 6 and 7 have no effect.
- R11: `cwp` wraps from 0 to NWIN-1 on a save and from NWIN-1 to 0 on a restore.
- R12: A load request (`req_op` = 5) sets `can_save`, `can_restore`, `other_win` and `clean_win` from `load_val` fields [CW-1:0], [2CW-1:CW], [3CW-1:2CW] and [4CW-1:3CW] respectively, where CW = clog2(NWIN). It leaves `cwp` unchanged and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code: 0 save, 1 restore, 2 saved, 3 restored, 4 flush, 5 load |
| wstate | input | 6 | Window-state selector bits for spill/fill trap types |
| load_val | input | 4*CW | Packed counter values for the load request |
| can_save | output | CW | Windows free for a call |
| can_restore | output | CW | Windows a return can reopen |
| other_win | output | CW | Windows owned by another context |
| clean_win | output | CW | Windows already scrubbed |
| cwp | output | CW | Active window pointer |
| trap_valid | output | 1 | A trap was raised by the previous request |
| trap_type | output | 9 | Trap type, 0 when no trap |

## Verification
A wrong counter inside this block stays hidden until a request consults it. A single wrong count then shows up one cycle later: either a trap is missing, or a spurious spill, fill or clean trap appears. The same problem can also show as a counter that fails to step. The sum of the save, restore and other counts is preserved by every request except load, so a lost or doubled step breaks that sum at the very next edge. A wrong pointer step is visible on `cwp` on the cycle after the save or restore. A wrong selector half in a trap type shows on `trap_type` in the same trap cycle.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [2:0] {
        OP_SAVE     = 3'd0,
        OP_RESTORE  = 3'd1,
        OP_SAVED    = 3'd2,
        OP_RESTORED = 3'd3,
        OP_FLUSH    = 3'd4,
        OP_LOAD     = 3'd5
    } win_op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_TRAP  = 1'b1
    } wsc_state_e;

    localparam logic [8:0] TT_SPILL_BASE = 9'h080;
    localparam logic [8:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [8:0] TT_OTHER_FLAG = 9'h020;
    localparam logic [8:0] TT_CLEAN      = 9'h024;

    function automatic logic [8:0] make_vector(
        input logic [8:0] base,
        input logic       other,
        input logic [5:0] ws
    );
        if (other) begin
            return base | TT_OTHER_FLAG | {4'b0000, ws[5:3], 2'b00};
        end
        return base | {4'b0000, ws[2:0], 2'b00};
    endfunction

endpackage

// File: rtl/wsc_ring_step.sv
module wsc_ring_step #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] down,
    output logic [CW-1:0] up
);
    localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            assign down = cur - 1'b1;
            assign up   = cur + 1'b1;
        end else begin : g_general
            assign down = (cur == '0)  ? TOP : cur - 1'b1;
            assign up   = (cur == TOP) ? '0  : cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/wsc_decide.sv
module wsc_decide
    import wsc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic [5:0]    ws,
    input  logic [4*CW-1:0] ld,
    input  logic [CW-1:0] cs,
    input  logic [CW-1:0] cr,
    input  logic [CW-1:0] ow,
    input  logic [CW-1:0] cln,
    output logic [CW-1:0] cs_n,
    output logic [CW-1:0] cr_n,
    output logic [CW-1:0] ow_n,
    output logic [CW-1:0] cln_n,
    output logic          go_down,
    output logic          go_up,
    output logic          trap,
    output logic [8:0]    trap_code
);
    localparam logic [CW-1:0] SAVE_FULL = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_TOP = CW'(NWIN - 1);

    win_op_e    op_e;
    logic       other_live;
    logic [8:0] spill_code;
    logic [8:0] fill_code;

    assign op_e       = win_op_e'(op);
    assign other_live = (ow != '0);
    assign spill_code = make_vector(TT_SPILL_BASE, other_live, ws);
    assign fill_code  = make_vector(TT_FILL_BASE, other_live, ws);

    always_comb begin
        cs_n      = cs;
        cr_n      = cr;
        ow_n      = ow;
        cln_n     = cln;
        go_down   = 1'b0;
        go_up     = 1'b0;
        trap      = 1'b0;
        trap_code = '0;
        if (valid) begin
            unique case (op_e)
                OP_SAVE: begin
                    if (cs == '0) begin
                        trap      = 1'b1;
                        trap_code = spill_code;
                    end else if (cln == cr) begin
                        trap      = 1'b1;
                        trap_code = TT_CLEAN;
                    end else begin
                        cs_n    = cs - 1'b1;
                        cr_n    = cr + 1'b1;
                        go_down = 1'b1;
                    end
                end
                OP_RESTORE: begin
                    if (cr == '0) begin
                        trap      = 1'b1;
                        trap_code = fill_code;
                    end else begin
                        cs_n  = cs + 1'b1;
                        cr_n  = cr - 1'b1;
                        go_up = 1'b1;
                    end
                end
                OP_SAVED: begin
                    cs_n = cs + 1'b1;
                    if (other_live) ow_n = ow - 1'b1;
                    else            cr_n = cr - 1'b1;
                end
                OP_RESTORED: begin
                    cr_n = cr + 1'b1;
                    if (cln < CLEAN_TOP) cln_n = cln + 1'b1;
                    if (other_live) ow_n = ow - 1'b1;
                    else            cs_n = cs - 1'b1;
                end
                OP_FLUSH: begin
                    if (cs != SAVE_FULL) begin
                        trap      = 1'b1;
                        trap_code = spill_code;
                    end
                end
                OP_LOAD: begin
                    cs_n  = ld[CW-1:0];
                    cr_n  = ld[2*CW-1:CW];
                    ow_n  = ld[3*CW-1:2*CW];
                    cln_n = ld[4*CW-1:3*CW];
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/wsc_unit.sv
module wsc_unit
    import wsc_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [5:0]      wstate,
    input  logic [4*CW-1:0] load_val,
    output logic [CW-1:0]   can_save,
    output logic [CW-1:0]   can_restore,
    output logic [CW-1:0]   other_win,
    output logic [CW-1:0]   clean_win,
    output logic [CW-1:0]   cwp,
    output logic            trap_valid,
    output logic [8:0]      trap_type
);
    wsc_state_e     state_q, state_d;
    logic [CW-1:0]  cs_q, cr_q, ow_q, cln_q, cwp_q;
    logic [CW-1:0]  cs_d, cr_d, ow_d, cln_d, cwp_d;
    logic [CW-1:0]  cwp_dn, cwp_up;
    logic           step_dn, step_up, trap_hit;
    logic [8:0]     code_d, code_q;

    wsc_decide #(.NWIN(NWIN)) u_decide (
        .valid     (req_valid),
        .op        (req_op),
        .ws        (wstate),
        .ld        (load_val),
        .cs        (cs_q),
        .cr        (cr_q),
        .ow        (ow_q),
        .cln       (cln_q),
        .cs_n      (cs_d),
        .cr_n      (cr_d),
        .ow_n      (ow_d),
        .cln_n     (cln_d),
        .go_down   (step_dn),
        .go_up     (step_up),
        .trap      (trap_hit),
        .trap_code (code_d)
    );

    wsc_ring_step #(.NWIN(NWIN)) u_ring (
        .cur  (cwp_q),
        .down (cwp_dn),
        .up   (cwp_up)
    );

    always_comb begin
        cwp_d = cwp_q;
        if (step_dn)      cwp_d = cwp_dn;
        else if (step_up) cwp_d = cwp_up;
    end

    always_comb begin
        unique case (state_q)
            ST_READY: state_d = trap_hit ? ST_TRAP : ST_READY;
            ST_TRAP:  state_d = trap_hit ? ST_TRAP : ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cs_q    <= CW'(NWIN - 2);
            cr_q    <= '0;
            ow_q    <= '0;
            cln_q   <= CW'(NWIN - 1);
            cwp_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs_d;
            cr_q    <= cr_d;
            ow_q    <= ow_d;
            cln_q   <= cln_d;
            cwp_q   <= cwp_d;
            code_q  <= trap_hit ? code_d : 9'h000;
        end
    end

    always_comb begin
        can_save    = cs_q;
        can_restore = cr_q;
        other_win   = ow_q;
        clean_win   = cln_q;
        cwp         = cwp_q;
        unique case (state_q)
            ST_TRAP: begin
                trap_valid = 1'b1;
                trap_type  = code_q;
            end
            default: begin
                trap_valid = 1'b0;
                trap_type  = 9'h000;
            end
        endcase
    end
endmodule

// File: rtl/wsc_unit_chk.sv
module wsc_unit_chk #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic [CW-1:0] can_save,
    input logic [CW-1:0] can_restore,
    input logic [CW-1:0] other_win,
    input logic [CW-1:0] clean_win,
    input logic [CW-1:0] cwp,
    input logic          trap_valid,
    input logic [8:0]    trap_type
);
    logic [CW-1:0] occ_sum;
    logic [CW-1:0] cwp_minus;
    assign occ_sum   = can_save + can_restore + other_win;
    assign cwp_minus = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;

    AST_TRAP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (can_save == $past(can_save) && can_restore == $past(can_restore)
                        && cwp == $past(cwp))); // R3

    AST_SPILL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && can_save == '0)
        |=> (trap_valid && trap_type[8:6] == 3'b010)); // R3

    AST_SUM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 3'd5) |=> (occ_sum == $past(occ_sum))); // R8

    AST_CLEAN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && clean_win == CW'(NWIN - 1))
        |=> (clean_win == CW'(NWIN - 1))); // R9

    AST_CODE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ((trap_type[8:6] == 3'b010 || trap_type[8:6] == 3'b011
                         || trap_type == 9'h024) && trap_type[1:0] == 2'b00)); // R6

    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_type == 9'h000)); // R10

    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && can_save != '0 && clean_win != can_restore)
        |=> (cwp == $past(cwp_minus) && !trap_valid)); // R11
endmodule

bind wsc_unit wsc_unit_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .can_save    (can_save),
    .can_restore (can_restore),
    .other_win   (other_win),
    .clean_win   (clean_win),
    .cwp         (cwp),
    .trap_valid  (trap_valid),
    .trap_type   (trap_type)
);

// File: tb/tb_wsc_unit.sv
`timescale 1ns/1ps
module tb_wsc_unit;
    localparam int NWIN = 8;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = 3'd0;
    logic [5:0]      wstate = 6'b101_011;
    logic [4*CW-1:0] load_val = '0;
    logic [CW-1:0]   can_save, can_restore, other_win, clean_win, cwp;
    logic            trap_valid;
    logic [8:0]      trap_type;

    int total = 0;
    int bad = 0;
    bit done = 0;

    wsc_unit #(.NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .wstate(wstate), .load_val(load_val), .can_save(can_save),
        .can_restore(can_restore), .other_win(other_win), .clean_win(clean_win),
        .cwp(cwp), .trap_valid(trap_valid), .trap_type(trap_type)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input int cs, input int cr, input int ow,
                              input int cln, input int p, input int tv, input int tt);
        check(req, "can_save", int'(can_save), cs);
        check(req, "can_restore", int'(can_restore), cr);
        check(req, "other_win", int'(other_win), ow);
        check(req, "clean_win", int'(clean_win), cln);
        check(req, "cwp", int'(cwp), p);
        check(req, "trap_valid", int'(trap_valid), tv);
        check(req, "trap_type", int'(trap_type), tt);
    endtask

    task automatic issue(input logic [2:0] op);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load(input int cs, input int cr, input int ow, input int cln);
        load_val = {CW'(cln), CW'(ow), CW'(cr), CW'(cs)};
        issue(3'd5);
    endtask

    task automatic t_reset;
        expect_all("R1", 6, 0, 0, 7, 0, 0, 0);
    endtask

    task automatic t_basic_wrap;
        issue(3'd1);
        expect_all("R5", 6, 0, 0, 7, 0, 1, 'h0CC);
        @(negedge clk);
        check("R10", "trap_valid one cycle", int'(trap_valid), 0);
        check("R10", "trap_type idle", int'(trap_type), 0);
        issue(3'd0);
        expect_all("R11", 5, 1, 0, 7, 7, 0, 0);
        issue(3'd1);
        expect_all("R11", 6, 0, 0, 7, 0, 0, 0);
        issue(3'd4);
        expect_all("R7", 6, 0, 0, 7, 0, 0, 0);
    endtask

    task automatic t_fill_ring;
        for (int i = 0; i < 6; i++) issue(3'd0);
        expect_all("R2", 0, 6, 0, 7, 2, 0, 0);
        issue(3'd4);
        expect_all("R7", 0, 6, 0, 7, 2, 1, 'h08C);
        issue(3'd0);
        expect_all("R3", 0, 6, 0, 7, 2, 1, 'h08C);
        issue(3'd2);
        expect_all("R8", 1, 5, 0, 7, 2, 0, 0);
        issue(3'd7);
        expect_all("R10", 1, 5, 0, 7, 2, 0, 0);
    endtask

    task automatic t_clean;
        load(2, 2, 2, 4);
        expect_all("R12", 2, 2, 2, 4, 2, 0, 0);
        issue(3'd0);
        expect_all("R2", 1, 3, 2, 4, 1, 0, 0);
        load(3, 3, 0, 3);
        issue(3'd0);
        expect_all("R4", 3, 3, 0, 3, 1, 1, 'h024);
    endtask

    task automatic t_other_ctx;
        load(0, 3, 3, 5);
        issue(3'd0);
        expect_all("R6", 0, 3, 3, 5, 1, 1, 'h0B4);
        load(3, 0, 3, 5);
        issue(3'd1);
        expect_all("R6", 3, 0, 3, 5, 1, 1, 'h0F4);
        wstate = 6'b010_110;
        issue(3'd4);
        expect_all("R6", 3, 0, 3, 5, 1, 1, 'h0A8);
        wstate = 6'b101_011;
    endtask

    task automatic t_handler;
        load(0, 3, 3, 5);
        issue(3'd2);
        expect_all("R8", 1, 3, 2, 5, 1, 0, 0);
        issue(3'd3);
        expect_all("R9", 1, 4, 1, 6, 1, 0, 0);
        issue(3'd3);
        expect_all("R9", 1, 5, 0, 7, 1, 0, 0);
        issue(3'd3);
        expect_all("R9", 0, 6, 0, 7, 1, 0, 0);
        issue(3'd6);
        expect_all("R10", 0, 6, 0, 7, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_wrap();
        t_fill_ring();
        t_clean();
        t_other_ctx();
        t_handler();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule